// File: doc/BRIEF.md
# Stored-Reference Output Checker with Recovery Window

This block judges a processor under fault injection by comparing each output word it produces against an expected-output table held in memory, rather than against a second copy of the processor running alongside it. The workload inputs are replayed to the processor from elsewhere. The checker only watches the processor's output bus and its valid strobe. It drives two read addresses into the table and receives the current and the following expected words in the same cycle.

Because software redundancy in the processor can spend extra cycles repairing a corrupted result, a mismatch does not count as a failure at once. The checker opens a recovery window whose length in clock cycles is programmable. If the output stream lines up with the table again inside that window, the event is counted as recovered and tracking resumes. Realignment on the following entry is also accepted, which covers a skipped output. If the window runs out, the checker latches the table index and the offending value and holds a failure flag until the next run starts.

Top module: `ref_table_checker`

## Requirements
- R1: After reset the state output is IDLE (code 0), `fail_o` and `done_o` are low, the table address and recovery count are zero, and valid outputs from the device are ignored until `start_i`.
- R2: A `start_i` pulse sets the table pointer to zero, the state to TRACKING (code 1) and the recovery count to zero, and it clears any failure, including a held FAILED state.
- R3: In TRACKING, a valid output equal to the current table word advances the pointer by exactly one. Cycles without `dut_valid_i` leave the pointer and the state unchanged.
- R4: In TRACKING with a non-zero window, a valid output that differs from the current word moves the state to RECOVERING (code 2) and leaves the pointer unchanged.
- R5: In RECOVERING, a valid output equal to the current word on any of the `win_len_i` cycles after the mismatching cycle returns the state to TRACKING, advances the pointer by one, and adds one to `recov_cnt_o`.
- R6: In RECOVERING, a valid output equal to the next word (address pointer+1) is accepted only when pointer+1 is below the table length. It advances the pointer by two, returns the state to TRACKING and adds one to `recov_cnt_o`. The next-word address output is always the pointer plus one.
- R7: If no realigning output arrives within `win_len_i` cycles after the mismatch, the state becomes FAILED (code 3) and `fail_o` rises. `fail_idx_o` holds the pointer and `fail_data_o` holds the latest mismatching output. All of these hold, and device outputs are ignored, until the next `start_i`.
- R8: With a window of zero, a valid mismatch in TRACKING goes straight to FAILED and latches the pointer and that output.
- R9: `done_o` is high exactly when the state is TRACKING and the pointer equals `tbl_len_i`. Valid outputs arriving after that are ignored.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new checking run |
| win_len_i | input | CW | Recovery window in cycles |
| tbl_len_i | input | AW | Number of table entries in the run |
| dut_valid_i | input | 1 | Device output-valid strobe |
| dut_data_i | input | DW | Device output word |
| tbl_cur_addr_o | output | AW | Read address of current expected word |
| tbl_nxt_addr_o | output | AW | Read address of following expected word |
| tbl_cur_data_i | input | DW | Expected word at current address |
| tbl_nxt_data_i | input | DW | Expected word at following address |
| state_o | output | 2 | 0 idle, 1 tracking, 2 recovering, 3 failed |
| fail_o | output | 1 | Failure flag |
| done_o | output | 1 | Run completed without failure |
| fail_idx_o | output | AW | Pointer when failure was declared |
| fail_data_o | output | DW | Last mismatching output at failure |
| recov_cnt_o | output | RW | Recovered events, saturating |

## Verification
The assertions assume that the table returns both words in the same cycle the addresses appear, and that `tbl_len_i` and `win_len_i` stay constant for the whole run. They also assume `start_i` is a single-cycle pulse. The bench models the table as a combinational array filled with distinct values and uses a mismatch value that appears nowhere in it. It changes the configuration only just before a start pulse and drives every input at the falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_RECOV = 2'd2,
    ST_FAIL  = 2'd3
  } rtc_state_e;
endpackage

// File: rtl/rtc_cmp.sv
module rtc_cmp #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic [DW-1:0] obs_i,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] nxt_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] len_i,
  output logic          hit_cur_o,
  output logic          hit_nxt_o
);
  logic [AW:0] ptr_p1;
  assign ptr_p1    = {1'b0, ptr_i} + {{AW{1'b0}}, 1'b1};
  assign hit_cur_o = (obs_i == cur_i);
  // next word only legal if it lies inside the table
  assign hit_nxt_o = (obs_i == nxt_i) && (ptr_p1 < {1'b0, len_i});
endmodule

// File: rtl/rtc_win.sv
module rtc_win #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] win_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW:0] cnt_p1;
  assign cnt_p1 = {1'b0, cnt_o} + {{CW{1'b0}}, 1'b1};
  assign last_o = en_i && (cnt_p1 == {1'b0, win_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i && !last_o) cnt_o <= cnt_p1[CW-1:0];
  end
endmodule

// File: rtl/rtc_cnt.sv
module rtc_cnt #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [RW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (inc_i && !(&cnt_o))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ref_table_checker.sv
module ref_table_checker
  import rtc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] win_len_i,
  input  logic [AW-1:0] tbl_len_i,
  input  logic          dut_valid_i,
  input  logic [DW-1:0] dut_data_i,
  output logic [AW-1:0] tbl_cur_addr_o,
  output logic [AW-1:0] tbl_nxt_addr_o,
  input  logic [DW-1:0] tbl_cur_data_i,
  input  logic [DW-1:0] tbl_nxt_data_i,
  output logic [1:0]    state_o,
  output logic          fail_o,
  output logic          done_o,
  output logic [AW-1:0] fail_idx_o,
  output logic [DW-1:0] fail_data_o,
  output logic [RW-1:0] recov_cnt_o
);
  rtc_state_e    st_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] last_bad_q;
  logic          hit_cur, hit_nxt, at_end, win_last, recov_ev;
  logic [CW-1:0] win_cnt;

  rtc_cmp #(.DW(DW), .AW(AW)) u_cmp (
    .obs_i(dut_data_i), .cur_i(tbl_cur_data_i), .nxt_i(tbl_nxt_data_i),
    .ptr_i(ptr_q), .len_i(tbl_len_i),
    .hit_cur_o(hit_cur), .hit_nxt_o(hit_nxt)
  );

  rtc_win #(.CW(CW)) u_win (
    .clk_i, .rst_ni,
    .clr_i(start_i || st_q != ST_RECOV),
    .en_i(st_q == ST_RECOV),
    .win_i(win_len_i),
    .cnt_o(win_cnt), .last_o(win_last)
  );

  assign recov_ev = !start_i && st_q == ST_RECOV && dut_valid_i && (hit_cur || hit_nxt);

  rtc_cnt #(.RW(RW)) u_rcnt (
    .clk_i, .rst_ni, .clr_i(start_i), .inc_i(recov_ev), .cnt_o(recov_cnt_o)
  );

  assign at_end = (ptr_q == tbl_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ptr_q       <= '0;
      last_bad_q  <= '0;
      fail_idx_o  <= '0;
      fail_data_o <= '0;
    end else if (start_i) begin
      st_q        <= ST_TRACK;
      ptr_q       <= '0;
      last_bad_q  <= '0;
      fail_idx_o  <= '0;
      fail_data_o <= '0;
    end else begin
      unique case (st_q)
        ST_TRACK: if (dut_valid_i && !at_end) begin
          if (hit_cur) begin
            ptr_q <= ptr_q + 1'b1;
          end else begin
            last_bad_q <= dut_data_i;
            if (win_len_i == '0) begin
              st_q        <= ST_FAIL;
              fail_idx_o  <= ptr_q;
              fail_data_o <= dut_data_i;
            end else begin
              st_q <= ST_RECOV;
            end
          end
        end
        ST_RECOV: begin
          if (dut_valid_i && hit_cur) begin
            ptr_q <= ptr_q + 1'b1;
            st_q  <= ST_TRACK;
          end else if (dut_valid_i && hit_nxt) begin
            ptr_q <= ptr_q + 2'd2;
            st_q  <= ST_TRACK;
          end else begin
            if (dut_valid_i) last_bad_q <= dut_data_i;
            if (win_last) begin
              st_q        <= ST_FAIL;
              fail_idx_o  <= ptr_q;
              fail_data_o <= dut_valid_i ? dut_data_i : last_bad_q;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign tbl_cur_addr_o = ptr_q;
  assign tbl_nxt_addr_o = ptr_q + 1'b1;
  assign state_o        = st_q;
  assign fail_o         = (st_q == ST_FAIL);
  assign done_o         = (st_q == ST_TRACK) && at_end;
endmodule

// File: rtl/ref_table_checker_chk.sv
module ref_table_checker_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int RW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [CW-1:0] win_len_i,
  input logic [AW-1:0] tbl_len_i,
  input logic          dut_valid_i,
  input logic [DW-1:0] dut_data_i,
  input logic [DW-1:0] tbl_cur_data_i,
  input logic [AW-1:0] tbl_cur_addr_o,
  input logic [1:0]    state_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_idx_o,
  input logic [DW-1:0] fail_data_o,
  input logic [RW-1:0] recov_cnt_o,
  input logic [CW-1:0] win_cnt_i
);
  p_ptr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !dut_valid_i) |=> $stable(tbl_cur_addr_o));

  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (tbl_cur_addr_o == $past(tbl_cur_addr_o)) ||
                 (tbl_cur_addr_o == $past(tbl_cur_addr_o) + 1'b1) ||
                 (tbl_cur_addr_o == $past(tbl_cur_addr_o) + 2'd2));

  p_recov_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && state_o != 2'd2) |=> $stable(recov_cnt_o));

  p_fail_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o && $stable(fail_idx_o) && $stable(fail_data_o));

  p_win_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> (win_cnt_i < win_len_i));

  p_zero_win_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && state_o == 2'd1 && dut_valid_i && dut_data_i != tbl_cur_data_i &&
     win_len_i == '0 && tbl_cur_addr_o != tbl_len_i) |=> fail_o);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_o == 2'd1) && (tbl_cur_addr_o == '0) && !fail_o);
endmodule

bind ref_table_checker ref_table_checker_chk #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .win_len_i(win_len_i),
  .tbl_len_i(tbl_len_i), .dut_valid_i(dut_valid_i), .dut_data_i(dut_data_i),
  .tbl_cur_data_i(tbl_cur_data_i), .tbl_cur_addr_o(tbl_cur_addr_o),
  .state_o(state_o), .fail_o(fail_o), .fail_idx_o(fail_idx_o),
  .fail_data_o(fail_data_o), .recov_cnt_o(recov_cnt_o), .win_cnt_i(win_cnt)
);

// File: tb/ref_table_checker_tb.sv
module ref_table_checker_tb;
  localparam int AW = 4, DW = 8, CW = 4, RW = 4;
  localparam logic [DW-1:0] BAD = 8'hEE;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, vld = 1'b0;
  logic [CW-1:0] win = '0;
  logic [AW-1:0] len = '0;
  logic [DW-1:0] dat = '0;
  logic [AW-1:0] cur_a, nxt_a, fidx;
  logic [DW-1:0] cur_d, nxt_d, fdat;
  logic [1:0]    st;
  logic          fail, done;
  logic [RW-1:0] rcnt;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] tv(input logic [AW-1:0] a);
    return 8'(a * 7 + 3);
  endfunction
  assign cur_d = tv(cur_a);
  assign nxt_d = tv(nxt_a);

  ref_table_checker #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .win_len_i(win),
    .tbl_len_i(len), .dut_valid_i(vld), .dut_data_i(dat),
    .tbl_cur_addr_o(cur_a), .tbl_nxt_addr_o(nxt_a),
    .tbl_cur_data_i(cur_d), .tbl_nxt_data_i(nxt_d),
    .state_o(st), .fail_o(fail), .done_o(done),
    .fail_idx_o(fidx), .fail_data_o(fdat), .recov_cnt_o(rcnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d);
    vld = v; dat = d;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic go(input logic [CW-1:0] w, input logic [AW-1:0] l);
    win = w; len = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // {vld, kind(0 cur,1 nxt,2 bad), exp state, exp addr, exp recov}
  localparam logic [12:0] VEC [15] = '{
    {1'b1, 2'd0, 2'd1, 4'd1, 4'd0},
    {1'b0, 2'd0, 2'd1, 4'd1, 4'd0},
    {1'b1, 2'd0, 2'd1, 4'd2, 4'd0},
    {1'b1, 2'd2, 2'd2, 4'd2, 4'd0},
    {1'b0, 2'd0, 2'd2, 4'd2, 4'd0},
    {1'b1, 2'd0, 2'd1, 4'd3, 4'd1},
    {1'b1, 2'd2, 2'd2, 4'd3, 4'd1},
    {1'b1, 2'd1, 2'd1, 4'd5, 4'd2},
    {1'b1, 2'd0, 2'd1, 4'd6, 4'd2},
    {1'b1, 2'd2, 2'd2, 4'd6, 4'd2},
    {1'b0, 2'd0, 2'd2, 4'd6, 4'd2},
    {1'b0, 2'd0, 2'd2, 4'd6, 4'd2},
    {1'b1, 2'd0, 2'd1, 4'd7, 4'd3},
    {1'b1, 2'd0, 2'd1, 4'd8, 4'd3},
    {1'b1, 2'd0, 2'd1, 4'd8, 4'd3}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] pa;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state, valid ignored in idle
    step(1'b1, tv(0));
    chk("R1 state", st, 0); chk("R1 fail", fail, 0); chk("R1 done", done, 0);
    chk("R1 addr", cur_a, 0); chk("R1 recov", rcnt, 0);

    // table walk: W=3, length 8
    go(4'd3, 4'd8);
    chk("R2 state", st, 1); chk("R2 addr", cur_a, 0);
    pa = '0;
    for (int i = 0; i < 15; i++) begin
      logic [DW-1:0] d;
      logic [12:0] v;
      v = VEC[i];
      d = (v[11:10] == 2'd0) ? tv(pa) : (v[11:10] == 2'd1) ? tv(pa + 1'b1) : BAD;
      step(v[12], d);
      chk("R3/R4/R5/R6 state", st, int'(v[9:8]));
      chk("R3/R5/R6 addr", cur_a, int'(v[7:4]));
      chk("R6 next addr", nxt_a, int'(v[7:4]) + 1);
      chk("R5 recov", rcnt, int'(v[3:0]));
      chk("R9 done", done, (v[7:4] == 4'd8 && v[9:8] == 2'd1) ? 1 : 0);
      chk("R7 fail", fail, 0);
      pa = v[7:4];
    end

    // R7 window expiry, W=2
    go(4'd2, 4'd8);
    step(1'b1, tv(0));
    step(1'b1, 8'hC5);
    chk("R4 state", st, 2);
    step(1'b0, '0);
    chk("R7 still recovering", st, 2);
    step(1'b0, '0);
    chk("R7 state", st, 3); chk("R7 fail", fail, 1);
    chk("R7 idx", fidx, 1); chk("R7 data", fdat, 8'hC5);
    step(1'b1, tv(1));
    chk("R7 hold state", st, 3); chk("R7 hold addr", cur_a, 1);
    chk("R7 hold data", fdat, 8'hC5); chk("R7 done low", done, 0);

    // R2 start clears failure
    go(4'd0, 4'd8);
    chk("R2 clr fail", fail, 0); chk("R2 clr recov", rcnt, 0); chk("R2 addr", cur_a, 0);

    // R8 zero window
    step(1'b1, 8'h55);
    chk("R8 state", st, 3); chk("R8 idx", fidx, 0); chk("R8 data", fdat, 8'h55);

    // R6 next word beyond length not accepted
    go(4'd3, 4'd2);
    step(1'b1, tv(0));
    step(1'b1, BAD);
    step(1'b1, tv(2));
    chk("R6 beyond len state", st, 2); chk("R6 beyond len addr", cur_a, 1);
    step(1'b1, tv(1));
    chk("R5 state", st, 1); chk("R9 done end", done, 1); chk("R5 recov", rcnt, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule